// File: doc/BRIEF.md
# Local Interval Countdown Timer

This block is the per-processor interval timer that sits beside a local interrupt controller. A free-running prescaler divides the input clock by a power of two chosen through a divide register. Each prescaled tick decrements a current-count register that software loads through the initial-count register. In one-shot mode the count runs down to zero once and stays there. In periodic mode it wraps back to the initial value after reaching zero.

Whenever the count reaches zero and the timer is not masked, the block drives a one-clock fire strobe together with the 8-bit vector from its control word. A downstream interrupt controller posts that vector. Priority handling and bus transport are outside this block. Software reaches the registers through a write port and a separate combinational read port. The current count can be read at any time.

Register selects are 0 = control word, 1 = initial count, 2 = current count (read only), 3 = divide.

Top module: `ltmr_top`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (masked, one-shot, vector 0). Initial count, current count and divide register all read 0, and fire is low.
- R2: The divide register (select 3) keeps only bits 3, 1 and 0. All other bits read back as 0.
- R3: The prescale shift is ({div[3],div[1:0]} + 1) mod 8, so divide value 0xB gives divide-by-1 and 0 gives divide-by-2. After an initial-count write at clock edge N, the k-th decrement lands on edge N + k·2^shift.
- R4: Writing the initial count (select 1) stores the value, loads it into the current count on the same edge, and restarts the prescaler phase. The stored value reads back unchanged.
- R5: In one-shot mode (control bit 17 = 0), t clocks after the load the current count is max(0, I − floor(t/2^shift)). Exactly one expiry occurs, on the tick where the count reaches 0.
- R6: In periodic mode (control bit 17 = 1) with I > 0, the count after d ticks is I − (d mod (I+1)). An expiry occurs every time the count reaches 0, which is once every I+1 ticks.
- R7: An initial count of 0 produces no expiry in either mode, and the current count stays 0.
- R8: While control bit 16 (mask) is set, no fire strobe is raised. The count keeps running exactly as when unmasked.
- R9: The fire strobe is high for exactly one clock, in the clock after the terminal tick. While it is high, fire_vec equals control bits 7:0.
- R10: The control word keeps only bits 17, 16 and 7:0. All other bits read back as 0.
- R11: Writes to the current-count select (2) are ignored, and counting continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 32 | Read data (combinational) |
| fire | output | 1 | One-clock expiry strobe |
| fire_vec | output | 8 | Vector to post, valid with fire |

## Verification
The bench aims at the following corner cases:

- **Divide encoding.** Every divide code is driven, including the wrap that gives divide-by-1 at 0xB. A design that decoded bit 2 instead of bit 3, or skipped the +1, would decrement at the wrong rate. That shows up on the first mismatching cycle.
- **Periodic period.** Periodic runs are checked over two full periods. A design that reloaded on the same tick as zero, with a period of I instead of I+1, would misplace the second strobe.
- **Zero count.** Runs with an initial count of zero catch a timer that fires or reloads spuriously.
- **Mask and read-only register.** Masked runs check that the mask silences only the strobe. A poke at the read-only current-count register must leave the per-cycle count sequence intact.

// File: rtl/ltmr_pkg.sv
`timescale 1ns/1ps
// ltmr_pkg: register selects, control-word bit positions and the divide
// decode shared by the interval timer and its checker.
package ltmr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_INIT = 2'd1,
        SEL_CURR = 2'd2,
        SEL_DIV  = 2'd3
    } reg_sel_e;

    localparam int CTRL_PERIODIC_BIT = 17;
    localparam int CTRL_MASK_BIT     = 16;
    localparam int VEC_W             = 8;
    localparam int DIV_W             = 4;
    localparam int SHIFT_W           = 3;

    // Turn the sparse divide field into a prescale shift (wraps mod 8).
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] dv);
        logic [SHIFT_W-1:0] code;
        code = {dv[3], dv[1:0]};
        return code + 3'd1;
    endfunction

endpackage

// File: rtl/ltmr_regs.sv
`timescale 1ns/1ps
// ltmr_regs: software-visible configuration storage.
// Holds the control word fields, the initial count and the divide field.
// Issues one-clock load strobes when the initial count or the divide
// register is written. Assumes DATA_W >= 18 so that all control bits fit.
module ltmr_regs
    import ltmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ctrl_mask,
    output logic              ctrl_periodic,
    output logic [VEC_W-1:0]  ctrl_vec,
    output logic [DATA_W-1:0] init_val,
    output logic [DIV_W-1:0]  div_val,
    output logic              init_load,
    output logic              div_load
);

    logic ctrl_wr;

    // Decode the write strobes per register.
    always_comb begin
        ctrl_wr   = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
        init_load = wr_en && (reg_sel_e'(wr_addr) == SEL_INIT);
        div_load  = wr_en && (reg_sel_e'(wr_addr) == SEL_DIV);
    end

    // Control word fields; reset leaves the timer masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_mask     <= 1'b1;
            ctrl_periodic <= 1'b0;
            ctrl_vec      <= '0;
        end else if (ctrl_wr) begin
            ctrl_mask     <= wr_data[CTRL_MASK_BIT];
            ctrl_periodic <= wr_data[CTRL_PERIODIC_BIT];
            ctrl_vec      <= wr_data[VEC_W-1:0];
        end
    end

    // Initial count storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_val <= '0;
        else if (init_load)
            init_val <= wr_data;
    end

    // Divide field, keeping only bits 3, 1 and 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_val <= '0;
        else if (div_load)
            div_val <= {wr_data[3], 1'b0, wr_data[1:0]};
    end

endmodule

// File: rtl/ltmr_prescale.sv
`timescale 1ns/1ps
// ltmr_prescale: free-running power-of-two prescaler.
// Raises tick once every 2^shift clocks. restart zeroes the phase so that
// the first tick lands 2^shift clocks after the restart edge.
// Assumes PRE_W > the largest shift (7).
module ltmr_prescale
    import ltmr_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    localparam logic [PRE_W-1:0] ONE = {{(PRE_W-1){1'b0}}, 1'b1};

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] phase_mask;

    // Phase counter, cleared on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            phase_q <= '0;
        else
            phase_q <= phase_q + ONE;
    end

    // Tick when all low shift bits of the phase are ones.
    always_comb begin
        phase_mask = (ONE << shift) - ONE;
        tick       = (phase_q & phase_mask) == phase_mask;
    end

endmodule

// File: rtl/ltmr_counter.sv
`timescale 1ns/1ps
// ltmr_counter: the current-count register and the expiry strobe.
// Loads on an initial-count write, decrements on each tick and reloads from
// the initial value one tick after reaching zero in periodic mode. Fires
// one clock after the tick that brings the count to zero, unless masked or
// overridden by a load on the same edge.
module ltmr_counter
    import ltmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic             mask,
    input  logic [VEC_W-1:0] vec_in,
    output logic [CNT_W-1:0] cur,
    output logic             fire,
    output logic [VEC_W-1:0] fire_vec
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cur_nxt;
    logic             hit_zero;

    // Next count and terminal-tick detection.
    always_comb begin
        hit_zero = tick && !load && (cur == ONE);
        if (load)
            cur_nxt = load_val;
        else if (!tick)
            cur_nxt = cur;
        else if (cur != '0)
            cur_nxt = cur - ONE;
        else if (periodic)
            cur_nxt = load_val;
        else
            cur_nxt = '0;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else
            cur <= cur_nxt;
    end

    // Registered strobe and vector capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire     <= 1'b0;
            fire_vec <= '0;
        end else begin
            fire <= hit_zero && !mask;
            if (hit_zero)
                fire_vec <= vec_in;
        end
    end

endmodule

// File: rtl/ltmr_top.sv
`timescale 1ns/1ps
// ltmr_top: per-processor interval timer.
// Ties the register file, the prescaler and the countdown together and
// provides a combinational read port. Writing the initial count or the
// divide register restarts the prescaler phase.
module ltmr_top
    import ltmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              fire,
    output logic [VEC_W-1:0]  fire_vec
);

    logic              ctrl_mask;
    logic              ctrl_periodic;
    logic [VEC_W-1:0]  ctrl_vec;
    logic [DATA_W-1:0] init_count;
    logic [DIV_W-1:0]  div_reg;
    logic              init_load;
    logic              div_load;
    logic              tick;
    logic [DATA_W-1:0] cur_count;
    logic [DATA_W-1:0] ctrl_word;

    ltmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_mask(ctrl_mask), .ctrl_periodic(ctrl_periodic),
        .ctrl_vec(ctrl_vec), .init_val(init_count), .div_val(div_reg),
        .init_load(init_load), .div_load(div_load)
    );

    ltmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(init_load || div_load),
        .shift(div_to_shift(div_reg)), .tick(tick)
    );

    ltmr_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(init_load),
        .load_val(init_load ? wr_data : init_count), .tick(tick),
        .periodic(ctrl_periodic), .mask(ctrl_mask), .vec_in(ctrl_vec),
        .cur(cur_count), .fire(fire), .fire_vec(fire_vec)
    );

    // Assemble the control word and select the read data.
    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[CTRL_PERIODIC_BIT] = ctrl_periodic;
        ctrl_word[CTRL_MASK_BIT]     = ctrl_mask;
        ctrl_word[VEC_W-1:0]         = ctrl_vec;
        case (reg_sel_e'(rd_addr))
            SEL_CTRL: rd_data = ctrl_word;
            SEL_INIT: rd_data = init_count;
            SEL_CURR: rd_data = cur_count;
            default:  rd_data = {{(DATA_W-DIV_W){1'b0}}, div_reg};
        endcase
    end

endmodule

// File: rtl/ltmr_checker.sv
`timescale 1ns/1ps
// ltmr_checker: temporal properties of the interval timer, bound to ltmr_top.
module ltmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             fire,
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] init,
    input logic             mask
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R9: strobe lasts a single clock
    a_r9_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R8: no strobe when the mask was set at the terminal tick
    a_r8_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !$past(mask));

    // R5: the strobe coincides with a zero count
    a_r5_fire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (cur == '0));

    // R7: a zero count with a zero initial value stays idle
    a_r7_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == '0 && init == '0 && !(wr_en && wr_addr == 2'd1))
        |=> (cur == '0 && !fire));

    // R3: without a load the count holds or steps down by one
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_addr == 2'd1) && cur != '0)
        |=> (cur == $past(cur) || cur == $past(cur) - ONE));

    // R4: an initial-count write loads the current count
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> (cur == $past(wr_data)));

endmodule

bind ltmr_top ltmr_checker #(.CNT_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fire(fire), .cur(cur_count), .init(init_count),
    .mask(ctrl_mask)
);

// File: tb/ltmr_top_tb.sv
`timescale 1ns/1ps
// ltmr_top_tb: directed corners plus seeded random runs, checked cycle by
// cycle against closed-form count and expiry formulas.
module ltmr_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd2;
    logic [31:0] rd_data;
    logic        fire;
    logic [7:0]  fire_vec;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ltmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .fire(fire), .fire_vec(fire_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
        rd_addr = 2'd2;
    endtask

    function automatic int shift_of(input logic [3:0] dv);
        logic [2:0] c;
        c = {dv[3], dv[1:0]};
        c = c + 3'd1;
        return int'(c);
    endfunction

    // Program, load, then check count and strobe every clock.
    task automatic run(input int ic, input logic [3:0] dv, input bit per,
                       input bit msk, input logic [7:0] vec, input int poke_t,
                       input string tag);
        int s;
        int n;
        int d;
        logic [31:0] ec;
        bit ef;
        s = shift_of(dv);
        wr(2'd0, {14'b0, per, msk, 8'b0, vec});
        wr(2'd3, {28'b0, dv});
        wr(2'd1, ic);
        n = (per ? 2 * ic + 3 : ic + 3) << s;
        chk({tag, " load"}, rd_data, ic);
        chk({tag, " no fire at load"}, {31'b0, fire}, 32'd0);
        for (int t = 1; t <= n; t++) begin
            @(negedge clk);
            wr_en = 1'b0;
            d = t >> s;
            if (per)
                ec = (ic == 0) ? 0 : ic - (d % (ic + 1));
            else
                ec = (d >= ic) ? 0 : ic - d;
            ef = !msk && ic > 0 && (t % (1 << s)) == 0 &&
                 (per ? (d % (ic + 1)) == ic : d == ic);
            chk({tag, " count"}, rd_data, ec);
            chk({tag, " fire R9"}, {31'b0, fire}, {31'b0, ef});
            if (ef) chk({tag, " vector R9"}, {24'b0, fire_vec}, {24'b0, vec});
            if (t == poke_t) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = $urandom;
            end
        end
    endtask

    initial begin
        logic [31:0] v;
        int ic;
        logic [3:0] dv;
        bit per;
        bit msk;
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0001_0000);
        rd(2'd1, v); chk("R1 init", v, 32'd0);
        rd(2'd2, v); chk("R1 curr", v, 32'd0);
        rd(2'd3, v); chk("R1 div", v, 32'd0);
        chk("R1 fire", {31'b0, fire}, 32'd0);

        // R2: divide keeps bits 3,1,0
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R2 div all ones", v, 32'hB);
        wr(2'd3, 32'h0000_0004); rd(2'd3, v); chk("R2 div bit2", v, 32'h0);

        // R10: control keeps bits 17,16,7:0
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R10 ctrl", v, 32'h0003_00FF);

        // R4: initial count readback and load
        wr(2'd0, 32'h0001_0000);
        wr(2'd1, 32'h0000_1234);
        rd(2'd1, v); chk("R4 init readback", v, 32'h1234);
        rd(2'd2, v); chk("R4 curr loaded", v, 32'h1234);

        // Directed corners
        run(0, 4'hB, 1'b1, 1'b0, 8'h11, 0, "R7 periodic zero");
        run(0, 4'h0, 1'b0, 1'b0, 8'h12, 0, "R7 one-shot zero");
        run(1, 4'hB, 1'b1, 1'b0, 8'h21, 0, "R3/R6 periodic I=1 div1");
        run(5, 4'h0, 1'b0, 1'b0, 8'h22, 0, "R3/R5 one-shot div2");
        run(3, 4'h3, 1'b1, 1'b0, 8'h33, 0, "R3/R6 periodic code3");
        run(2, 4'h8, 1'b0, 1'b0, 8'h44, 0, "R3/R5 one-shot code4");
        run(4, 4'h2, 1'b1, 1'b1, 8'h55, 0, "R8 masked periodic");
        run(6, 4'h1, 1'b1, 1'b0, 8'h66, 5, "R11 curr write ignored");

        // Seeded random runs
        for (int k = 0; k < 12; k++) begin
            ic  = $urandom_range(0, 10);
            dv  = 4'($urandom);
            per = 1'($urandom_range(0, 1));
            msk = ($urandom_range(0, 4) == 0);
            run(ic, dv, per, msk, 8'($urandom), 0,
                per ? "R6 random periodic" : "R5 random one-shot");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule